// File: doc/BRIEF.md
# Pulse-Interval Programming Command Decoder

This block turns a train of supply-modulation pulses into programming commands. A large start strobe arms the decoder, sets the instruction state to its first function and clears the data word. A settling wait follows, counted in timebase ticks. Small pulses that arrive during that wait are ignored. The first small pulse after the wait serves only as a timing reference. After that, every small pulse is classified by the number of timebase ticks since the pulse before it. A short gap steps the instruction state. A medium gap shifts a 0 into the data word, a long gap shifts a 1, and a gap longer than all windows is a timeout.

The instruction state runs through six functions in a fixed order: 1 oscillator measurement, 2 inhibition-time measurement, 3 write/check word A, 4 write/check word B, 5 check word C, 6 check word D (type identification). The state stops at 6. When the eighth data bit arrives in state 3 or state 4, a write strobe pulses for one cycle so that the whole word can be programmed in one step. In the check states, the low bits of the data word serve as the index of the stored bit to present.

Top module: `pulse_cmd_decoder`

## Requirements
- R1: After reset, instr_state_o is 0, word_o is 0x00, wr_strobe_o is 0 and chk_index_o is 0. Small pulses have no effect until a start strobe arrives.
- R2: A start strobe sets instr_state_o to 1 and word_o to 0x00, and clears the bit count. It wins over a small pulse in the same cycle and can be given at any time.
- R3: For SETTLE_TICKS ticks after the start strobe (default 33), small pulses are ignored. A pulse on the SETTLE_TICKS-th tick cycle is still ignored.
- R4: The first small pulse after the settling wait only sets the timing reference. It changes neither the state nor the word.
- R5: The interval is the number of tick cycles strictly between two small pulses. An interval below ZERO_MIN (default 39) increments instr_state_o.
- R6: An interval from ZERO_MIN to ONE_MIN-1 (39..71) shifts a 0 into word bit 0, and the older bits move one place toward bit 7.
- R7: An interval from ONE_MIN to ONE_MAX (72..104) shifts a 1 into word bit 0 in the same way.
- R8: An interval above ONE_MAX (105 or more) takes no action. That pulse becomes the new reference.
- R9: instr_state_o stops at 6. Further increments leave it at 6, and only a start strobe returns it to 1.
- R10: wr_strobe_o is high for exactly one cycle, in the cycle in which word_o first shows the eighth bit, and only in states 3 and 4. In other states the bit count wraps after eight bits without a strobe.
- R11: An increment clears the bit count, so the next eight data bits form a complete word. The word contents are kept.
- R12: chk_index_o always equals bits 2:0 of word_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Large-pulse start strobe, one cycle |
| pulse_i | input | 1 | Small-pulse strobe, synchronised, one cycle |
| tick_i | input | 1 | Timebase tick enable |
| instr_state_o | output | 3 | Current instruction state (0 = not armed, 1..6) |
| word_o | output | 8 | Serial data word |
| wr_strobe_o | output | 1 | One-cycle word write strobe |
| chk_index_o | output | 3 | Check-pointer bit index |

## Verification
Some rules hold on every cycle, and the assertions check these. The state moves only by one step up or by a restart, and it never passes 6. Every data event shifts the word by one place with the right new bit. A start leaves state 1 and an empty word. The write strobe lasts one cycle and only appears in states 3 and 4. Other behaviour can only be shown by the bench's scenarios, because it depends on exact timing. These are the window edges at 38/39, 71/72 and 104/105 ticks, the pulse on the last settling tick, the reference-only first pulse, the timeout re-arm, and the strobe landing on exactly the eighth bit after an increment.

// File: rtl/pcd_pkg.sv
package pcd_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETTLE,
    PH_REF,
    PH_RUN
  } phase_t;

  typedef enum logic [1:0] {
    IV_INC,
    IV_ZERO,
    IV_ONE,
    IV_TIMEOUT
  } ivl_t;

  localparam logic [2:0] ST_FIRST  = 3'd1;
  localparam logic [2:0] ST_LAST   = 3'd6;
  localparam logic [2:0] ST_WORD_A = 3'd3;
  localparam logic [2:0] ST_WORD_B = 3'd4;

  // Map a tick count to a command class using three window edges.
  function automatic ivl_t classify(input int unsigned cnt,
                                    input int unsigned zero_min,
                                    input int unsigned one_min,
                                    input int unsigned one_max);
    if (cnt < zero_min)      return IV_INC;
    else if (cnt < one_min)  return IV_ZERO;
    else if (cnt <= one_max) return IV_ONE;
    else                     return IV_TIMEOUT;
  endfunction

  function automatic logic is_write_state(input logic [2:0] st);
    return (st == ST_WORD_A) || (st == ST_WORD_B);
  endfunction

endpackage

// File: rtl/pcd_interval_meter.sv
module pcd_interval_meter #(
  parameter int unsigned LIMIT = 105,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);

  // Saturating tick counter; a clear wins over a tick in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
    end else if (clr_i) begin
      count_o <= '0;
    end else if (tick_i && (count_o != CNT_W'(LIMIT))) begin
      count_o <= count_o + 1'b1;
    end
  end

endmodule

// File: rtl/pcd_sequencer.sv
module pcd_sequencer
  import pcd_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 33,
  localparam int unsigned SCNT_W = $clog2(SETTLE_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pulse_i,
  input  logic       tick_i,
  input  logic       ev_inc_i,
  output phase_t     phase_o,
  output logic [2:0] state_o
);

  logic [SCNT_W-1:0] settle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_o    <= PH_IDLE;
      settle_cnt <= '0;
      state_o    <= '0;
    end else if (start_i) begin
      phase_o    <= PH_SETTLE;
      settle_cnt <= '0;
      state_o    <= ST_FIRST;
    end else begin
      unique case (phase_o)
        PH_SETTLE: begin
          if (tick_i) begin
            if (settle_cnt == SCNT_W'(SETTLE_TICKS - 1)) phase_o <= PH_REF;
            else                                         settle_cnt <= settle_cnt + 1'b1;
          end
        end
        PH_REF: begin
          if (pulse_i) phase_o <= PH_RUN;
        end
        PH_RUN: begin
          if (ev_inc_i && (state_o < ST_LAST)) state_o <= state_o + 3'd1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pcd_shift_word.sv
module pcd_shift_word #(
  parameter int unsigned WORD_W = 8,
  localparam int unsigned BCNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ev_inc_i,
  input  logic              ev_bit_i,
  input  logic              bit_i,
  input  logic              wr_en_i,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_strobe_o
);

  logic [BCNT_W-1:0] bit_cnt;
  logic              last_bit;

  assign last_bit = (bit_cnt == BCNT_W'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_o      <= '0;
      bit_cnt     <= '0;
      wr_strobe_o <= 1'b0;
    end else if (clr_i) begin
      word_o      <= '0;
      bit_cnt     <= '0;
      wr_strobe_o <= 1'b0;
    end else begin
      wr_strobe_o <= 1'b0;
      if (ev_inc_i) begin
        bit_cnt <= '0;
      end else if (ev_bit_i) begin
        word_o <= {word_o[WORD_W-2:0], bit_i};
        if (last_bit) begin
          bit_cnt     <= '0;
          wr_strobe_o <= wr_en_i;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pulse_cmd_decoder.sv
module pulse_cmd_decoder
  import pcd_pkg::*;
#(
  parameter int unsigned WORD_W       = 8,
  parameter int unsigned SETTLE_TICKS = 33,
  parameter int unsigned ZERO_MIN     = 39,
  parameter int unsigned ONE_MIN      = 72,
  parameter int unsigned ONE_MAX      = 104,
  localparam int unsigned CNT_LIMIT   = ONE_MAX + 1,
  localparam int unsigned CNT_W       = $clog2(CNT_LIMIT + 1),
  localparam int unsigned IDX_W       = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              pulse_i,
  input  logic              tick_i,
  output logic [2:0]        instr_state_o,
  output logic [WORD_W-1:0] word_o,
  output logic              wr_strobe_o,
  output logic [IDX_W-1:0]  chk_index_o
);

  phase_t           phase;
  logic [CNT_W-1:0] ivl_count;
  ivl_t             ivl_class;

  // Named internal events, visible to the bound checker.
  logic meas_pulse;
  logic ev_inc;
  logic ev_bit0;
  logic ev_bit1;
  logic ev_timeout;

  assign meas_pulse = pulse_i && !start_i && (phase == PH_RUN);
  assign ivl_class  = classify(32'(ivl_count), ZERO_MIN, ONE_MIN, ONE_MAX);
  assign ev_inc     = meas_pulse && (ivl_class == IV_INC);
  assign ev_bit0    = meas_pulse && (ivl_class == IV_ZERO);
  assign ev_bit1    = meas_pulse && (ivl_class == IV_ONE);
  assign ev_timeout = meas_pulse && (ivl_class == IV_TIMEOUT);

  pcd_interval_meter #(
    .LIMIT (CNT_LIMIT)
  ) u_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (start_i | pulse_i),
    .tick_i  (tick_i),
    .count_o (ivl_count)
  );

  pcd_sequencer #(
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .pulse_i  (pulse_i),
    .tick_i   (tick_i),
    .ev_inc_i (ev_inc),
    .phase_o  (phase),
    .state_o  (instr_state_o)
  );

  pcd_shift_word #(
    .WORD_W (WORD_W)
  ) u_word (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (start_i),
    .ev_inc_i    (ev_inc),
    .ev_bit_i    (ev_bit0 | ev_bit1),
    .bit_i       (ev_bit1),
    .wr_en_i     (is_write_state(instr_state_o)),
    .word_o      (word_o),
    .wr_strobe_o (wr_strobe_o)
  );

  assign chk_index_o = word_o[IDX_W-1:0];

endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [2:0]        instr_state_o,
  input logic [WORD_W-1:0] word_o,
  input logic              wr_strobe_o,
  input logic              ev_bit0,
  input logic              ev_bit1
);

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (instr_state_o == 3'd1) && (word_o == '0) && !wr_strobe_o);

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (instr_state_o == $past(instr_state_o)) ||
                 (instr_state_o == $past(instr_state_o) + 3'd1));

  assert_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit0 |=> (word_o[0] == 1'b0) && (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));

  assert_bit1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bit1 |=> (word_o[0] == 1'b1) && (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));

  assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_bit0 && !ev_bit1 && !start_i) |=> $stable(word_o));

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    instr_state_o <= 3'd6);

  assert_wr_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |-> (instr_state_o == 3'd3) || (instr_state_o == 3'd4));

  assert_wr_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

endmodule

bind pulse_cmd_decoder pcd_checker #(.WORD_W(WORD_W)) u_pcd_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .instr_state_o (instr_state_o),
  .word_o        (word_o),
  .wr_strobe_o   (wr_strobe_o),
  .ev_bit0       (ev_bit0),
  .ev_bit1       (ev_bit1)
);

// File: tb/tb_pulse_cmd_decoder.sv
`timescale 1ns/1ps
module tb_pulse_cmd_decoder;

  localparam int SETTLE = 33;
  localparam int NVEC   = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       pulse_i = 1'b0;
  logic       tick_i = 1'b1;
  logic [2:0] instr_state_o;
  logic [7:0] word_o;
  logic       wr_strobe_o;
  logic [2:0] chk_index_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pulse_cmd_decoder #(
    .WORD_W(8), .SETTLE_TICKS(SETTLE), .ZERO_MIN(39), .ONE_MIN(72), .ONE_MAX(104)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .pulse_i(pulse_i), .tick_i(tick_i),
    .instr_state_o(instr_state_o), .word_o(word_o), .wr_strobe_o(wr_strobe_o),
    .chk_index_o(chk_index_o)
  );

  // {gap ticks, expected state, expected word, expected strobe}
  localparam logic [19:0] VEC [NVEC] = '{
    {8'd38,  3'd2, 8'h00, 1'b0},  // R5 edge: 38 -> increment
    {8'd10,  3'd3, 8'h00, 1'b0},  // R5
    {8'd72,  3'd3, 8'h01, 1'b0},  // R7 edge: 72 -> one
    {8'd39,  3'd3, 8'h02, 1'b0},  // R6 edge: 39 -> zero
    {8'd104, 3'd3, 8'h05, 1'b0},  // R7 edge: 104 -> one
    {8'd80,  3'd3, 8'h0B, 1'b0},  // R7
    {8'd71,  3'd3, 8'h16, 1'b0},  // R6 edge: 71 -> zero
    {8'd50,  3'd3, 8'h2C, 1'b0},  // R6
    {8'd90,  3'd3, 8'h59, 1'b0},  // R7
    {8'd60,  3'd3, 8'hB2, 1'b1},  // R10: eighth bit in state 3
    {8'd105, 3'd3, 8'hB2, 1'b0},  // R8: timeout edge
    {8'd3,   3'd4, 8'hB2, 1'b0},  // R8: timed-out pulse is new reference
    {8'd80,  3'd4, 8'h65, 1'b0},  // R7
    {8'd0,   3'd5, 8'h65, 1'b0},  // R5: zero gap
    {8'd20,  3'd6, 8'h65, 1'b0},  // R5
    {8'd20,  3'd6, 8'h65, 1'b0}   // R9: saturation
  };

  task automatic check_out(input string tag, input logic [2:0] st,
                           input logic [7:0] wd, input logic wr);
    n_chk++;
    if (instr_state_o !== st || word_o !== wd || wr_strobe_o !== wr ||
        chk_index_o !== wd[2:0]) begin
      n_bad++;
      $display("FAIL %s: got state=%0d word=%h wr=%b idx=%0d, want state=%0d word=%h wr=%b idx=%0d",
               tag, instr_state_o, word_o, wr_strobe_o, chk_index_o, st, wd, wr, wd[2:0]);
    end
  endtask

  // gap idle tick cycles, then one pulse cycle; returns just after that edge.
  task automatic send(input int gap);
    repeat (gap) @(posedge clk);
    @(negedge clk) pulse_i = 1'b1;
    @(posedge clk);
    #1 pulse_i = 1'b0;
  endtask

  task automatic do_start(input logic with_pulse);
    @(negedge clk);
    start_i = 1'b1;
    pulse_i = with_pulse;
    @(posedge clk);
    #1 start_i = 1'b0;
    pulse_i = 1'b0;
  endtask

  task automatic arm();
    do_start(1'b0);
    repeat (SETTLE + 4) @(posedge clk);
    send(0);  // reference pulse
  endtask

  task automatic send_bit(input logic b);
    send(b ? 85 : 55);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check_out("R1 reset", 3'd0, 8'h00, 1'b0);
    send(10);
    send(50);
    send(90);
    check_out("R1 pulses ignored before start", 3'd0, 8'h00, 1'b0);

    // R2: start with simultaneous pulse
    do_start(1'b1);
    check_out("R2 start wins over pulse", 3'd1, 8'h00, 1'b0);

    // R3: pulse on last settling tick ignored; R4 next pulse is reference only
    send(SETTLE - 1);
    check_out("R3 pulse during settle", 3'd1, 8'h00, 1'b0);
    send(0);
    check_out("R4 reference pulse", 3'd1, 8'h00, 1'b0);
    send(5);
    check_out("R3 R5 first measured increment", 3'd2, 8'h00, 1'b0);

    // Table walk
    arm();
    for (int i = 0; i < NVEC; i++) begin
      send(int'(VEC[i][19:12]));
      check_out($sformatf("vector %0d (R5-R10)", i), VEC[i][11:9], VEC[i][8:1], VEC[i][0]);
    end

    // R2: start from state 6 clears word
    do_start(1'b0);
    check_out("R2 restart from state 6", 3'd1, 8'h00, 1'b0);

    // R11: partial word discarded by increment
    repeat (SETTLE + 4) @(posedge clk);
    send(0);
    send(5);
    send(5);
    check_out("R11 in state 3", 3'd3, 8'h00, 1'b0);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    check_out("R11 three bits", 3'd3, 8'h07, 1'b0);
    send(5);
    check_out("R11 increment keeps word", 3'd4, 8'h07, 1'b0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
    check_out("R11 no strobe on fifth bit after increment", 3'd4, 8'hE1, 1'b0);
    send_bit(1'b1); send_bit(1'b1);
    check_out("R11 seventh bit", 3'd4, 8'h87, 1'b0);
    send_bit(1'b1);
    check_out("R10 strobe on eighth bit in state 4", 3'd4, 8'h0F, 1'b1);
    @(posedge clk); #1;
    check_out("R10 strobe lasts one cycle", 3'd4, 8'h0F, 1'b0);

    // R10: no strobe in state 5
    send(5);
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    check_out("R10 no strobe in state 5", 3'd5, 8'hFF, 1'b0);
    send_bit(1'b0);
    check_out("R12 index after wrap", 3'd5, 8'hFE, 1'b0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule